// File: doc/BRIEF.md
# Precise Exception Tracking Pipeline

This block is the exception and cancellation control of a five-stage in-order pipeline: fetch, decode, execute, memory, writeback. It owns the fetch address. Each stage register carries three things with its instruction: a valid bit, the instruction's address and an exception code. A fault is recorded in the stage where it is found. A fetch fault is recorded at fetch, an illegal instruction in execute and a bad data address in memory. The fault travels with the instruction and takes effect only when that instruction reaches writeback.

When an instruction reaches writeback with a code, the block takes the exception. The faulting instruction and all younger instructions are aborted, while older instructions have already committed. The block records the cause and the exception address, enters kernel mode (which also masks interrupts) and redirects fetch to a fixed handler address. A store in the memory stage during that cycle has its write blocked.

Conditional branches resolve in the memory stage, and fetch assumes they are not taken. A taken branch turns the three younger instructions into bubbles and discards any fault codes they carry. An external interrupt is taken at the writeback boundary. Its exception address is the next instruction that would have run.

Top module: `exc_track_pipe`

## Requirements
- R1: After reset, fetch_pc equals RESET_PC, all four stage valids are 0, cause is 0 and kernel_mode is 0.
- R2: Without a redirect, fetch_pc advances by 4 each cycle and each instruction moves one stage per cycle. An instruction fetched in cycle n is in writeback in cycle n+4 and commits there (wb_commit high) if it has no fault.
- R3: Fault codes are 1 for a fetch fault (if_fault, sampled against fetch_pc), 2 for an illegal instruction (ex_illegal, against the execute stage) and 3 for a data-address fault (mem_bad_addr, against the memory stage). The exception is taken (take_exc high) in the cycle the faulting instruction is in writeback. That instruction does not commit, and from the next cycle cause holds its code and epc holds its address.
- R4: In the cycle after an exception is taken, fetch_pc equals HANDLER_PC, all four stage valids are 0 and kernel_mode is 1.
- R5: When several instructions carry faults, the oldest one is taken, even if a younger instruction was flagged in an earlier cycle.
- R6: mem_store_en is high only for a valid, fault-free instruction in the memory stage that requests a store. It is low in any cycle where an exception is taken, and low when the store itself has a data-address fault.
- R7: A taken branch in the memory stage computes target = address + 4 + sign_extend(mem_br_disp) * 4. It empties the decode, execute and memory stage registers on the next edge and loads fetch_pc with the target.
- R8: Instructions cancelled by a taken branch never raise an exception, whatever faults were flagged on them.
- R9: With irq high and kernel_mode 0, an interrupt is taken (cause 4). The writeback instruction still commits. epc is the address of the oldest remaining instruction in memory, execute or decode, or else fetch_pc.
- R10: irq is ignored while kernel_mode is 1.
- R11: An internal fault in writeback takes precedence over a pending interrupt. An exception taken in the same cycle as a taken branch overrides the branch redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_fault | input | 1 | Fetch of fetch_pc faulted |
| ex_illegal | input | 1 | Instruction in execute is illegal |
| mem_bad_addr | input | 1 | Instruction in memory has a bad data address |
| mem_store | input | 1 | Instruction in memory requests a store |
| mem_br_taken | input | 1 | Branch in memory resolved taken |
| mem_br_disp | input | DISP_W | Word displacement of that branch |
| irq | input | 1 | External interrupt request |
| fetch_pc | output | AW | Address being fetched |
| id_valid | output | 1 | Decode stage holds an instruction |
| id_pc | output | AW | Decode stage address |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_pc | output | AW | Execute stage address |
| mem_valid | output | 1 | Memory stage holds an instruction |
| mem_pc | output | AW | Memory stage address |
| wb_valid | output | 1 | Writeback stage holds an instruction |
| wb_pc | output | AW | Writeback stage address |
| wb_commit | output | 1 | Writeback instruction completes this cycle |
| mem_store_en | output | 1 | Store write permitted this cycle |
| take_exc | output | 1 | Exception or interrupt taken this cycle |
| br_squash | output | 1 | Taken branch cancels younger instructions |
| cause | output | 3 | Recorded exception code |
| epc | output | AW | Recorded exception address |
| kernel_mode | output | 1 | Kernel flag (interrupts masked) |

## Verification
Suppose a stage register keeps a fault code that a branch should have cleared. The result is a spurious take_exc about two cycles later, when the cancelled slot would have reached writeback, followed by a jump of fetch_pc to the handler. A fault that is dropped or merged wrongly shows as a wrong cause or epc on the cycle after the take, or as a younger instruction winning over an older one. A flush that misses a stage shows up on the next cycle as a stage valid still high, and a store that was not blocked shows up as mem_store_en high in the take cycle itself.

// File: rtl/exc_track_pkg.sv
package exc_track_pkg;

  typedef enum logic [2:0] {
    EXC_NONE    = 3'd0,
    EXC_FETCH   = 3'd1,
    EXC_ILLEGAL = 3'd2,
    EXC_DADDR   = 3'd3,
    EXC_IRQ     = 3'd4
  } exc_code_t;

  // Code attached by the fault check feeding stage register idx
  // (0: into decode, 1: into execute, 2: into memory, 3: into writeback).
  function automatic exc_code_t stage_fault_code(input int idx);
    case (idx)
      0:       return EXC_FETCH;
      2:       return EXC_ILLEGAL;
      3:       return EXC_DADDR;
      default: return EXC_NONE;
    endcase
  endfunction

  // An earlier recorded code is kept; otherwise a new fault is added.
  function automatic exc_code_t merge_code(input exc_code_t carried,
                                           input logic fault,
                                           input exc_code_t fresh);
    if (carried != EXC_NONE) return carried;
    if (fault)               return fresh;
    return EXC_NONE;
  endfunction

endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_track_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          squash,
  input  logic          in_valid,
  input  logic [AW-1:0] in_pc,
  input  exc_code_t     in_code,
  input  logic          fault,
  input  exc_code_t     fault_code,
  output logic          out_valid,
  output logic [AW-1:0] out_pc,
  output exc_code_t     out_code
);

  always_ff @(posedge clk) begin
    if (!rst_n || squash) begin
      out_valid <= 1'b0;
      out_pc    <= '0;
      out_code  <= EXC_NONE;
    end else begin
      out_valid <= in_valid;
      out_pc    <= in_pc;
      out_code  <= in_valid ? merge_code(in_code, fault, fault_code) : EXC_NONE;
    end
  end

endmodule

// File: rtl/exc_fetch_unit.sv
module exc_fetch_unit #(
  parameter int              AW         = 32,
  parameter int              DISP_W     = 21,
  parameter logic [AW-1:0]   RESET_PC   = '0,
  parameter logic [AW-1:0]   HANDLER_PC = AW'(32'h100)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_exc,
  input  logic              redirect_br,
  input  logic [AW-1:0]     br_pc,
  input  logic [DISP_W-1:0] br_disp,
  output logic [AW-1:0]     fetch_pc,
  output logic [AW-1:0]     br_target
);

  localparam logic [AW-1:0] STEP = AW'(4);

  function automatic logic [AW-1:0] calc_target(input logic [AW-1:0] pc,
                                                input logic [DISP_W-1:0] disp);
    logic [AW-1:0] sx;
    sx = AW'($signed(disp));
    return pc + STEP + (sx << 2);
  endfunction

  assign br_target = calc_target(br_pc, br_disp);

  // R4 / R7 / R11: handler redirect outranks branch redirect
  always_ff @(posedge clk) begin
    if (!rst_n)            fetch_pc <= RESET_PC;
    else if (redirect_exc) fetch_pc <= HANDLER_PC;
    else if (redirect_br)  fetch_pc <= br_target;
    else                   fetch_pc <= fetch_pc + STEP;
  end

endmodule

// File: rtl/exc_commit_arbiter.sv
module exc_commit_arbiter
  import exc_track_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_valid,
  input  logic [AW-1:0] wb_pc,
  input  exc_code_t     wb_code,
  input  logic          irq,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_pc,
  input  logic          ex_valid,
  input  logic [AW-1:0] ex_pc,
  input  logic          id_valid,
  input  logic [AW-1:0] id_pc,
  input  logic [AW-1:0] fetch_pc,
  output logic          take_int,
  output logic          take_irq,
  output logic          take_exc,
  output logic          wb_commit,
  output exc_code_t     cause,
  output logic [AW-1:0] epc,
  output logic          kernel_mode
);

  // R9: resume point of an interrupt is the oldest instruction not yet done
  function automatic logic [AW-1:0] resume_pc(
    input logic mv, input logic [AW-1:0] mp,
    input logic ev, input logic [AW-1:0] ep,
    input logic iv, input logic [AW-1:0] ip,
    input logic [AW-1:0] fp);
    if (mv) return mp;
    if (ev) return ep;
    if (iv) return ip;
    return fp;
  endfunction

  // R3 / R11: an internal fault at writeback wins over an interrupt
  assign take_int  = wb_valid && (wb_code != EXC_NONE);
  // R10: interrupts masked in kernel mode
  assign take_irq  = irq && !kernel_mode && !take_int;
  assign take_exc  = take_int || take_irq;
  assign wb_commit = wb_valid && !take_int;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause       <= EXC_NONE;
      epc         <= '0;
      kernel_mode <= 1'b0;
    end else if (take_exc) begin
      kernel_mode <= 1'b1;
      if (take_int) begin
        cause <= wb_code;
        epc   <= wb_pc;
      end else begin
        cause <= EXC_IRQ;
        epc   <= resume_pc(mem_valid, mem_pc, ex_valid, ex_pc,
                           id_valid, id_pc, fetch_pc);
      end
    end
  end

endmodule

// File: rtl/exc_track_pipe.sv
module exc_track_pipe
  import exc_track_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            DISP_W     = 21,
  parameter logic [AW-1:0] RESET_PC   = '0,
  parameter logic [AW-1:0] HANDLER_PC = AW'(32'h100)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_fault,
  input  logic              ex_illegal,
  input  logic              mem_bad_addr,
  input  logic              mem_store,
  input  logic              mem_br_taken,
  input  logic [DISP_W-1:0] mem_br_disp,
  input  logic              irq,
  output logic [AW-1:0]     fetch_pc,
  output logic              id_valid,
  output logic [AW-1:0]     id_pc,
  output logic              ex_valid,
  output logic [AW-1:0]     ex_pc,
  output logic              mem_valid,
  output logic [AW-1:0]     mem_pc,
  output logic              wb_valid,
  output logic [AW-1:0]     wb_pc,
  output logic              wb_commit,
  output logic              mem_store_en,
  output logic              take_exc,
  output logic              br_squash,
  output logic [2:0]        cause,
  output logic [AW-1:0]     epc,
  output logic              kernel_mode
);

  localparam int NSTG = 4;            // stage registers behind fetch
  localparam int MEMI = NSTG - 1;     // index of the memory stage slot

  // slot 0 is the fetch slot, slots 1..NSTG are the stage registers
  logic          st_valid [NSTG+1];
  logic [AW-1:0] st_pc    [NSTG+1];
  exc_code_t     st_code  [NSTG+1];

  logic [NSTG-1:0] stg_fault;
  logic [NSTG-1:0] stg_squash;
  logic            take_int;
  logic            take_irq;
  logic            mem_clean;
  logic [AW-1:0]   br_target;
  exc_code_t       cause_q;

  assign st_valid[0] = 1'b1;
  assign st_pc[0]    = fetch_pc;
  assign st_code[0]  = EXC_NONE;

  // fault checks feeding registers: fetch, none at decode, execute, memory
  assign stg_fault = {mem_bad_addr, ex_illegal, 1'b0, if_fault};

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    // R7: branch flush reaches only the three younger registers
    if (g < NSTG - 1) begin : g_young
      assign stg_squash[g] = take_exc || br_squash;
    end else begin : g_old
      assign stg_squash[g] = take_exc;
    end

    exc_stage_reg #(.AW(AW)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .squash     (stg_squash[g]),
      .in_valid   (st_valid[g]),
      .in_pc      (st_pc[g]),
      .in_code    (st_code[g]),
      .fault      (stg_fault[g]),
      .fault_code (stage_fault_code(g)),
      .out_valid  (st_valid[g+1]),
      .out_pc     (st_pc[g+1]),
      .out_code   (st_code[g+1])
    );
  end

  // memory-stage instruction is fault free so far and not being aborted
  assign mem_clean = st_valid[MEMI] && (st_code[MEMI] == EXC_NONE) &&
                     !mem_bad_addr && !take_exc;

  // R6 / R7 / R8 / R11
  assign br_squash    = mem_clean && mem_br_taken;
  assign mem_store_en = mem_clean && mem_store;

  exc_fetch_unit #(
    .AW(AW), .DISP_W(DISP_W), .RESET_PC(RESET_PC), .HANDLER_PC(HANDLER_PC)
  ) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .redirect_exc (take_exc),
    .redirect_br  (br_squash),
    .br_pc        (st_pc[MEMI]),
    .br_disp      (mem_br_disp),
    .fetch_pc     (fetch_pc),
    .br_target    (br_target)
  );

  exc_commit_arbiter #(.AW(AW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_valid    (st_valid[NSTG]),
    .wb_pc       (st_pc[NSTG]),
    .wb_code     (st_code[NSTG]),
    .irq         (irq),
    .mem_valid   (st_valid[3]),
    .mem_pc      (st_pc[3]),
    .ex_valid    (st_valid[2]),
    .ex_pc       (st_pc[2]),
    .id_valid    (st_valid[1]),
    .id_pc       (st_pc[1]),
    .fetch_pc    (fetch_pc),
    .take_int    (take_int),
    .take_irq    (take_irq),
    .take_exc    (take_exc),
    .wb_commit   (wb_commit),
    .cause       (cause_q),
    .epc         (epc),
    .kernel_mode (kernel_mode)
  );

  assign cause     = cause_q;
  assign id_valid  = st_valid[1];
  assign id_pc     = st_pc[1];
  assign ex_valid  = st_valid[2];
  assign ex_pc     = st_pc[2];
  assign mem_valid = st_valid[3];
  assign mem_pc    = st_pc[3];
  assign wb_valid  = st_valid[4];
  assign wb_pc     = st_pc[4];

endmodule

// File: rtl/exc_track_chk.sv
module exc_track_chk #(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] HANDLER_PC = AW'(32'h100)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] fetch_pc,
  input logic          id_valid,
  input logic          ex_valid,
  input logic          mem_valid,
  input logic          wb_valid,
  input logic [AW-1:0] wb_pc,
  input logic          wb_commit,
  input logic          mem_store_en,
  input logic          take_exc,
  input logic          take_int,
  input logic          take_irq,
  input logic          br_squash,
  input logic [AW-1:0] br_target,
  input logic [AW-1:0] epc,
  input logic          kernel_mode
);

  // R4
  handler_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (fetch_pc == HANDLER_PC) && !id_valid && !ex_valid &&
                 !mem_valid && !wb_valid && kernel_mode);

  // R3
  no_commit_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |-> !wb_commit);

  // R3
  epc_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |=> epc == $past(wb_pc));

  // R6
  store_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> !mem_store_en);

  // R7
  branch_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_squash |=> !id_valid && !ex_valid && !mem_valid &&
                  (fetch_pc == $past(br_target)));

  // R10
  kernel_irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kernel_mode |-> !take_irq);

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_exc && !br_squash) |=> fetch_pc == $past(fetch_pc) + AW'(4));

  // R4
  kernel_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kernel_mode) |-> $past(take_exc));

endmodule

bind exc_track_pipe exc_track_chk #(.AW(AW), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_pc     (fetch_pc),
  .id_valid     (id_valid),
  .ex_valid     (ex_valid),
  .mem_valid    (mem_valid),
  .wb_valid     (wb_valid),
  .wb_pc        (wb_pc),
  .wb_commit    (wb_commit),
  .mem_store_en (mem_store_en),
  .take_exc     (take_exc),
  .take_int     (take_int),
  .take_irq     (take_irq),
  .br_squash    (br_squash),
  .br_target    (br_target),
  .epc          (epc),
  .kernel_mode  (kernel_mode)
);

// File: tb/test_exc_track_pipe.sv
module test_exc_track_pipe;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] HANDLER    = 32'h100;
  localparam logic [31:0] NOPC       = 32'hDEAD_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        if_fault, ex_illegal, mem_bad_addr, mem_store, mem_br_taken, irq;
  logic [20:0] mem_br_disp;
  logic [31:0] fetch_pc, id_pc, ex_pc, mem_pc, wb_pc, epc;
  logic        id_valid, ex_valid, mem_valid, wb_valid, wb_commit;
  logic        mem_store_en, take_exc, br_squash, kernel_mode;
  logic [2:0]  cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_track_pipe i_exc_track_pipe (
    .clk(clk), .rst_n(rst_n), .if_fault(if_fault), .ex_illegal(ex_illegal),
    .mem_bad_addr(mem_bad_addr), .mem_store(mem_store),
    .mem_br_taken(mem_br_taken), .mem_br_disp(mem_br_disp), .irq(irq),
    .fetch_pc(fetch_pc), .id_valid(id_valid), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .mem_valid(mem_valid),
    .mem_pc(mem_pc), .wb_valid(wb_valid), .wb_pc(wb_pc),
    .wb_commit(wb_commit), .mem_store_en(mem_store_en),
    .take_exc(take_exc), .br_squash(br_squash), .cause(cause), .epc(epc),
    .kernel_mode(kernel_mode)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc;

  // scenario controls
  logic [31:0] f_if, f_ex, f_mem, br_at, st_a, st_b, st_c, irq_wb;
  logic [20:0] disp;
  logic        irq_hold;

  // observation logs
  logic [31:0] clog [64];
  int          ccnt;
  int          first_commit_cyc;
  logic [31:0] slog [16];
  int          scnt;
  int          tcnt;
  int          take_cyc;
  int          ccnt_at_take;
  logic        took_prev;
  logic        post_ok;

  task automatic chk(input logic cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic cycle();
    @(negedge clk);
    cyc++;
    if_fault     = (fetch_pc == f_if);
    ex_illegal   = ex_valid && (ex_pc == f_ex);
    mem_bad_addr = mem_valid && (mem_pc == f_mem);
    mem_br_taken = mem_valid && (mem_pc == br_at);
    mem_br_disp  = disp;
    mem_store    = mem_valid && (mem_pc == st_a || mem_pc == st_b || mem_pc == st_c);
    if (wb_valid && wb_pc == irq_wb) irq_hold = 1'b1;
    irq = irq_hold;
    #1;
    if (took_prev)
      post_ok = (fetch_pc == HANDLER) && !id_valid && !ex_valid &&
                !mem_valid && !wb_valid && kernel_mode;
    took_prev = 1'b0;
    if (wb_commit) begin
      if (ccnt == 0) first_commit_cyc = cyc;
      if (ccnt < 64) clog[ccnt] = wb_pc;
      ccnt++;
    end
    if (mem_store_en) begin
      if (scnt < 16) slog[scnt] = mem_pc;
      scnt++;
    end
    if (take_exc) begin
      if (tcnt == 0) begin
        take_cyc     = cyc;
        ccnt_at_take = ccnt;
      end
      tcnt++;
      took_prev = 1'b1;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic reset_dut();
    f_if = NOPC; f_ex = NOPC; f_mem = NOPC; br_at = NOPC;
    st_a = NOPC; st_b = NOPC; st_c = NOPC; irq_wb = NOPC;
    disp = '0; irq_hold = 1'b0;
    if_fault = 0; ex_illegal = 0; mem_bad_addr = 0; mem_store = 0;
    mem_br_taken = 0; mem_br_disp = '0; irq = 0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0; ccnt = 0; scnt = 0; tcnt = 0; take_cyc = -1;
    ccnt_at_take = -1; first_commit_cyc = -1;
    took_prev = 1'b0; post_ok = 1'b0;
    #1;
  endtask

  task automatic check_taken(input string req, input logic [2:0] exp_cause,
                             input logic [31:0] exp_epc, input int exp_commits);
    chk(tcnt == 1, req, "exception count", tcnt, 1);
    chk(cause == exp_cause, req, "cause", {29'd0, cause}, {29'd0, exp_cause});
    chk(epc == exp_epc, req, "epc", epc, exp_epc);
    chk(ccnt_at_take == exp_commits, req, "commits up to take",
        ccnt_at_take, exp_commits);
    chk(post_ok, "R4", "handler redirect and flush", {31'd0, post_ok}, 1);
  endtask

  task automatic t_reset();
    reset_dut();
    chk(fetch_pc == 32'h0, "R1", "fetch_pc", fetch_pc, 0);
    chk(!id_valid && !ex_valid && !mem_valid && !wb_valid, "R1", "stage valids",
        {28'd0, id_valid, ex_valid, mem_valid, wb_valid}, 0);
    chk(cause == 3'd0 && !kernel_mode, "R1", "cause/kernel",
        {28'd0, kernel_mode, cause}, 0);
  endtask

  task automatic t_flow();
    reset_dut();
    run(10);
    chk(first_commit_cyc == 4, "R2", "first commit cycle", first_commit_cyc, 4);
    chk(clog[0] == 0 && clog[1] == 4 && clog[5] == 32'h14, "R2", "commit order",
        clog[5], 32'h14);
    chk(fetch_pc == 32'd40, "R2", "fetch_pc after 10 cycles", fetch_pc, 40);
    chk(tcnt == 0, "R2", "no exception", tcnt, 0);
  endtask

  task automatic t_illegal();
    reset_dut();
    f_ex = 32'h10;
    run(12);
    chk(take_cyc == 8, "R3", "illegal taken at writeback cycle", take_cyc, 8);
    check_taken("R3", 3'd2, 32'h10, 4);
  endtask

  task automatic t_fetch_fault();
    reset_dut();
    f_if = 32'h8;
    run(12);
    check_taken("R3", 3'd1, 32'h8, 2);
  endtask

  task automatic t_data_fault_store();
    reset_dut();
    f_mem = 32'h14;
    st_a = 32'h10; st_b = 32'h14; st_c = 32'h18;
    run(12);
    check_taken("R3", 3'd3, 32'h14, 5);
    chk(scnt == 1, "R6", "store count", scnt, 1);
    chk(slog[0] == 32'h10, "R6", "older store performed", slog[0], 32'h10);
  endtask

  task automatic t_oldest_wins();
    reset_dut();
    f_if = 32'h14; f_ex = 32'h10;
    run(12);
    check_taken("R5", 3'd2, 32'h10, 4);
    reset_dut();
    f_mem = 32'h8; f_ex = 32'hC;
    run(12);
    check_taken("R5", 3'd3, 32'h8, 2);
  endtask

  task automatic t_branch_fwd();
    reset_dut();
    br_at = 32'h8; disp = 21'd5; f_ex = 32'hC; f_if = 32'h14;
    run(14);
    chk(tcnt == 0, "R8", "squashed faults ignored", tcnt, 0);
    chk(cause == 3'd0 && !kernel_mode, "R8", "cause stays clear",
        {28'd0, kernel_mode, cause}, 0);
    chk(clog[2] == 32'h8 && clog[3] == 32'h20, "R7", "commit after branch",
        clog[3], 32'h20);
    chk(clog[4] == 32'h24, "R7", "target successor", clog[4], 32'h24);
  endtask

  task automatic t_branch_back();
    reset_dut();
    br_at = 32'h8; disp = 21'h1FFFFD;
    run(14);
    chk(clog[3] == 32'h0 && clog[4] == 32'h4, "R7", "backward target",
        clog[3], 0);
    chk(tcnt == 0, "R7", "no exception", tcnt, 0);
  endtask

  task automatic t_irq();
    reset_dut();
    irq_wb = 32'h8;
    run(20);
    chk(take_cyc == 6, "R9", "interrupt cycle", take_cyc, 6);
    check_taken("R9", 3'd4, 32'hC, 3);
    chk(clog[2] == 32'h8, "R9", "writeback instruction commits", clog[2], 32'h8);
    chk(tcnt == 1 && irq, "R10", "held irq masked in kernel", tcnt, 1);
  endtask

  task automatic t_priority();
    reset_dut();
    f_ex = 32'h10; irq_wb = 32'h10;
    run(14);
    check_taken("R11", 3'd2, 32'h10, 4);
    reset_dut();
    f_ex = 32'h4; br_at = 32'h8; disp = 21'd5;
    run(14);
    check_taken("R11", 3'd2, 32'h4, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_flow();
    t_illegal();
    t_fetch_fault();
    t_data_fault_store();
    t_oldest_wins();
    t_branch_fwd();
    t_branch_back();
    t_irq();
    t_priority();
    finish_run();
  end

endmodule